// File: doc/BRIEF.md
# Cache-Block Zero Store Engine

This engine carries out one "zero this cache block" request at a time. A request gives a byte address and a flag that marks the target as an I/O region. The engine clears the low address bits to find the start of the block. The block size is a power of two, held in a small configuration register. The engine then offers the whole block to an external permission checker. Only after the checker grants store access does it write zeros over the block.

Normal memory is cleared with full bus words, every byte strobe set, one word per beat. An I/O region is still cleared, but as a run of single-byte stores in increasing address order, one per byte of the block. A denied permission check, or a fault returned by the memory port on any beat, ends the request with a store fault. A denied check ends it before any write is issued. Either way the engine reports completion for one cycle and then accepts the next request.

Top module: `blkzero_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `chk_valid`, `mem_valid`, `done` and `cfg_err` are 0, and the block size is 64 bytes.
- R2: A configuration write with a size that is a power of two, at least the bus width (8 bytes) and at most 4096 bytes is taken and clears `cfg_err`. Any other size sets `cfg_err` and leaves the previous block size in use.
- R3: The engine presents `chk_addr` as the request address with its low log2(block size) bits cleared, and presents `chk_len` equal to the block size.
- R4: No write beat is issued until the checker answers with `chk_ok`=1. A denial ends the request with `done_fault`=1 and zero write beats.
- R5: For normal memory (`req_io`=0) the engine issues block size / 8 beats with `mem_strb`=8'hFF, `mem_data`=0 and addresses base, base+8, base+16, and so on.
- R6: For an I/O region (`req_io`=1) the engine issues block size beats at addresses base, base+1, base+2, and so on. Each beat has exactly one strobe bit set, the bit at index address[2:0].
- R7: While `mem_valid` is 1 and `mem_ready` is 0, the beat (`mem_valid`, `mem_addr`, `mem_strb`) is held unchanged.
- R8: A beat accepted with `mem_fault`=1 is the last beat of the request. The request ends with `done_fault`=1.
- R9: `req_ready` is 0 from acceptance until the engine is idle again. A request held on `req_valid` during that time is not taken.
- R10: `done` is high for exactly one cycle per request. `done_fault` is 1 only with a denial or a beat fault. The cycle after `done`, `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Block size configuration write strobe |
| cfg_size | input | 13 | Requested block size in bytes |
| cfg_err | output | 1 | Last configuration write was rejected |
| req_valid | input | 1 | Zero request present |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_addr | input | 32 | Byte address inside the target block |
| req_io | input | 1 | Target is an I/O region (byte stores) |
| chk_valid | output | 1 | Permission query active |
| chk_addr | output | 32 | Aligned block base under query |
| chk_len | output | 13 | Length in bytes under query |
| chk_resp_valid | input | 1 | Checker answer present |
| chk_ok | input | 1 | Store permitted for the whole block |
| mem_valid | output | 1 | Write beat present |
| mem_ready | input | 1 | Write beat accepted |
| mem_addr | output | 32 | Write beat byte address |
| mem_data | output | 64 | Write data (always zero) |
| mem_strb | output | 8 | Byte strobes |
| mem_fault | input | 1 | Permission fault on the accepted beat |
| done | output | 1 | Request completed (one cycle) |
| done_fault | output | 1 | Request ended with a store fault |

## Verification
The assertions assume a checker answer arrives only while `chk_valid` is high, and that `mem_ready` and `mem_fault` mean something only during a write beat. The bench answers the checker only on a cycle where it sees `chk_valid`. It raises `mem_ready` and `mem_fault` only on cycles where `mem_valid` is high, and returns them to zero otherwise. Configuration writes are made only while the engine is idle, so the block size seen by the checker and by the write beats is the one in force at acceptance.

// File: rtl/blkzero_pkg.sv
package blkzero_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CHECK   = 3'd1,
    ST_WR_WORD = 3'd2,
    ST_WR_BYTE = 3'd3,
    ST_DONE    = 3'd4
  } zstate_t;
endpackage

// File: rtl/blkzero_cfg.sv
module blkzero_cfg #(
  parameter int SIZE_W    = 13,
  parameter int BUS_BYTES = 8,
  parameter int MAX_BLOCK = 4096,
  parameter int DEF_BLOCK = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic [SIZE_W-1:0] size_q,
  output logic              cfg_err
);
  localparam logic [SIZE_W-1:0] BUS_SZ = SIZE_W'(BUS_BYTES);
  localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(MAX_BLOCK);
  localparam logic [SIZE_W-1:0] DEF_SZ = SIZE_W'(DEF_BLOCK);

  logic size_ok;
  logic size_en;
  logic err_en;
  logic err_d;

  always_comb begin
    size_ok = (cfg_size != '0) &&
              ((cfg_size & (cfg_size - 1'b1)) == '0) &&
              (cfg_size >= BUS_SZ) && (cfg_size <= MAX_SZ);
    size_en = cfg_we && size_ok;
    err_en  = cfg_we;
    err_d   = !size_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= DEF_SZ;
    end else if (size_en) begin
      size_q <= cfg_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
    end else if (err_en) begin
      cfg_err <= err_d;
    end
  end

  // R2: the size in use is always a legal power of two
  a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(size_q) == 1) && (size_q >= BUS_SZ) && (size_q <= MAX_SZ));

  // R2: a rejected write keeps the previous size
  a_r2_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !size_ok) |=> ($stable(size_q) && cfg_err));
endmodule

// File: rtl/blkzero_beat.sv
module blkzero_beat #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 13,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_io,
  input  logic [SIZE_W-1:0] blk_size,
  output logic [ADDR_W-1:0] base_q,
  output logic [SIZE_W-1:0] len_q,
  output logic              io_q,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [BUS_BYTES-1:0] beat_strb,
  output logic              last_beat
);
  localparam int LANE_W = $clog2(BUS_BYTES);
  localparam int PAD_W  = ADDR_W - SIZE_W;
  localparam logic [SIZE_W-1:0] WORD_STEP = SIZE_W'(BUS_BYTES);
  localparam logic [SIZE_W-1:0] BYTE_STEP = SIZE_W'(1);

  logic [SIZE_W-1:0] off_q;
  logic [SIZE_W-1:0] off_d;
  logic [SIZE_W-1:0] step_w;
  logic [ADDR_W-1:0] align_mask;
  logic [ADDR_W-1:0] base_d;
  logic              off_en;
  logic              hold_en;

  always_comb begin
    step_w     = io_q ? BYTE_STEP : WORD_STEP;
    align_mask = {{PAD_W{1'b0}}, blk_size - 1'b1};
    base_d     = req_addr & ~align_mask;
    hold_en    = start;
    off_en     = start || advance;
    off_d      = start ? '0 : (off_q + step_w);
    last_beat  = ((off_q + step_w) == len_q);
    beat_addr  = base_q + {{PAD_W{1'b0}}, off_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      io_q   <= 1'b0;
    end else if (hold_en) begin
      base_q <= base_d;
      len_q  <= blk_size;
      io_q   <= req_io;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_d;
    end
  end

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign beat_strb[i] = !io_q || (off_q[LANE_W-1:0] == LANE_W'(i));
  end

  // R5/R6: each accepted beat moves the address by one step
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (beat_addr == $past(beat_addr) + {{PAD_W{1'b0}}, $past(step_w)}));
endmodule

// File: rtl/blkzero_fsm.sv
module blkzero_fsm
  import blkzero_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    chk_resp_valid,
  input  logic    chk_ok,
  input  logic    io_sel,
  input  logic    mem_ready,
  input  logic    mem_fault,
  input  logic    last_beat,
  output zstate_t state_q,
  output logic    start,
  output logic    advance,
  output logic    fault_q
);
  zstate_t state_d;
  logic    fault_d;
  logic    fault_en;
  logic    writing;

  always_comb begin
    state_d  = state_q;
    fault_d  = 1'b0;
    fault_en = 1'b0;
    start    = 1'b0;
    advance  = 1'b0;
    writing  = (state_q == ST_WR_WORD) || (state_q == ST_WR_BYTE);
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          start   = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (chk_resp_valid) begin
          if (chk_ok) begin
            state_d = io_sel ? ST_WR_BYTE : ST_WR_WORD;
          end else begin
            state_d  = ST_DONE;
            fault_d  = 1'b1;
            fault_en = 1'b1;
          end
        end
      end
      ST_WR_WORD, ST_WR_BYTE: begin
        if (mem_ready) begin
          if (mem_fault) begin
            state_d  = ST_DONE;
            fault_d  = 1'b1;
            fault_en = 1'b1;
          end else begin
            advance = 1'b1;
            if (last_beat) begin
              state_d  = ST_DONE;
              fault_en = 1'b1;
            end
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

  // R8: a faulting beat ends the request with a fault
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (writing && mem_ready && mem_fault) |=> (state_q == ST_DONE) && fault_q);

  // R10: completion lasts one cycle
  a_r10_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/blkzero_engine.sv
module blkzero_engine
  import blkzero_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  parameter int MAX_BLOCK = 4096,
  parameter int DEF_BLOCK = 64,
  localparam int SIZE_W   = $clog2(MAX_BLOCK) + 1,
  localparam int DATA_W   = BUS_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SIZE_W-1:0]    cfg_size,
  output logic                 cfg_err,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_io,
  output logic                 chk_valid,
  output logic [ADDR_W-1:0]    chk_addr,
  output logic [SIZE_W-1:0]    chk_len,
  input  logic                 chk_resp_valid,
  input  logic                 chk_ok,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_data,
  output logic [BUS_BYTES-1:0] mem_strb,
  input  logic                 mem_fault,
  output logic                 done,
  output logic                 done_fault
);
  localparam int PAD_W = ADDR_W - SIZE_W;

  zstate_t           state_q;
  logic              start;
  logic              advance;
  logic              fault_q;
  logic [SIZE_W-1:0] size_q;
  logic              io_q;
  logic              last_beat;

  blkzero_cfg #(
    .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES),
    .MAX_BLOCK(MAX_BLOCK), .DEF_BLOCK(DEF_BLOCK)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .size_q(size_q), .cfg_err(cfg_err)
  );

  blkzero_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .chk_resp_valid(chk_resp_valid), .chk_ok(chk_ok), .io_sel(io_q),
    .mem_ready(mem_ready), .mem_fault(mem_fault), .last_beat(last_beat),
    .state_q(state_q), .start(start), .advance(advance), .fault_q(fault_q)
  );

  blkzero_beat #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)
  ) u_beat (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .req_addr(req_addr), .req_io(req_io), .blk_size(size_q),
    .base_q(chk_addr), .len_q(chk_len), .io_q(io_q),
    .beat_addr(mem_addr), .beat_strb(mem_strb), .last_beat(last_beat)
  );

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    chk_valid  = (state_q == ST_CHECK);
    mem_valid  = (state_q == ST_WR_WORD) || (state_q == ST_WR_BYTE);
    mem_data   = '0;
    done       = (state_q == ST_DONE);
    done_fault = done && fault_q;
  end

  // R3: the queried base sits on a block boundary
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> ((chk_addr & {{PAD_W{1'b0}}, chk_len - 1'b1}) == '0));

  // R4: writing starts only right after a grant
  a_r4_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(chk_resp_valid && chk_ok));

  // R5: word beats write every byte lane
  a_r5_word_strb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !io_q) |-> (&mem_strb));

  // R6: byte beats write exactly one lane
  a_r6_byte_strb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && io_q) |-> ($countones(mem_strb) == 1));

  // R7: a stalled beat is held
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_strb)));
endmodule

// File: tb/sim_blkzero_engine.sv
module sim_blkzero_engine;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [12:0] cfg_size;
  logic        cfg_err;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        req_io;
  logic        chk_valid;
  logic [31:0] chk_addr;
  logic [12:0] chk_len;
  logic        chk_resp_valid;
  logic        chk_ok;
  logic        mem_valid;
  logic        mem_ready;
  logic [31:0] mem_addr;
  logic [63:0] mem_data;
  logic [7:0]  mem_strb;
  logic        mem_fault;
  logic        done;
  logic        done_fault;

  int n_total;
  int n_fail;

  blkzero_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_io(req_io), .chk_valid(chk_valid),
    .chk_addr(chk_addr), .chk_len(chk_len), .chk_resp_valid(chk_resp_valid),
    .chk_ok(chk_ok), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_strb(mem_strb),
    .mem_fault(mem_fault), .done(done), .done_fault(done_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [12:0] sz);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_size = sz;
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  // Runs one request; returns beat count, fault flag and mismatch counters.
  task automatic run_op(input logic [31:0] addr, input bit io, input bit permit,
                        input bit stall, input int fault_at, input bit hold_req,
                        input int exp_len,
                        output int beats, output bit saw_fault,
                        output int bad_beat, output int bad_chk,
                        output int bad_busy, output int bad_hold);
    logic [31:0] base;
    logic [31:0] prev_addr;
    logic [7:0]  prev_strb;
    logic        prev_stalled;
    bit          wait_once;
    bit          finished;
    int          step;
    base = addr & ~(32'(exp_len) - 32'd1);
    step = io ? 1 : 8;
    beats = 0; saw_fault = 1'b0; bad_beat = 0; bad_chk = 0; bad_busy = 0; bad_hold = 0;
    prev_stalled = 1'b0; prev_addr = '0; prev_strb = '0; wait_once = 1'b0;
    finished = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    req_io    = io;
    for (int cyc = 0; cyc < 20000 && !finished; cyc++) begin
      @(negedge clk);
      if (hold_req) begin
        req_addr = addr ^ 32'h0000_1000;
      end else begin
        req_valid = 1'b0;
      end
      if (req_ready) bad_busy++;
      chk_resp_valid = chk_valid;
      chk_ok         = permit;
      if (chk_valid) begin
        if (chk_addr != base || 32'(chk_len) != 32'(exp_len)) bad_chk++;
      end
      mem_ready = 1'b0;
      mem_fault = 1'b0;
      if (mem_valid) begin
        if (prev_stalled && (mem_addr != prev_addr || mem_strb != prev_strb)) bad_hold++;
        if (stall && !wait_once) begin
          wait_once    = 1'b1;
          prev_stalled = 1'b1;
          prev_addr    = mem_addr;
          prev_strb    = mem_strb;
        end else begin
          wait_once    = 1'b0;
          prev_stalled = 1'b0;
          mem_ready    = 1'b1;
          if (mem_addr != base + 32'(beats * step)) bad_beat++;
          if (io) begin
            if (mem_strb != (8'd1 << ((base + 32'(beats)) & 32'd7))) bad_beat++;
          end else begin
            if (mem_strb != 8'hFF) bad_beat++;
          end
          if (mem_data != 64'd0) bad_beat++;
          mem_fault = (beats == fault_at);
          beats++;
        end
      end
      if (done) begin
        saw_fault = done_fault;
        req_valid = 1'b0;
        finished  = 1'b1;
      end
    end
    mem_ready = 1'b0;
    mem_fault = 1'b0;
    chk_resp_valid = 1'b0;
    check(finished, "R10", "request completed", finished, 1);
    @(negedge clk);
    check(!done && req_ready, "R10", "done single cycle then idle",
          {done, req_ready}, 2'b01);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(!chk_valid && !mem_valid, "R1", "no activity after reset",
          {chk_valid, mem_valid}, 0);
    check(!done && !cfg_err, "R1", "done/cfg_err after reset", {done, cfg_err}, 0);
  endtask

  task automatic t_word_default;
    int b; bit f; int bb, bc, bu, bh;
    run_op(32'h1234_5677, 1'b0, 1'b1, 1'b0, -1, 1'b0, 64, b, f, bb, bc, bu, bh);
    check(b == 8, "R5", "word beats for 64B (R1 default size)", b, 8);
    check(bb == 0, "R5", "word beat address/strobe/data errors", bb, 0);
    check(bc == 0, "R3", "aligned base and length", bc, 0);
    check(!f, "R10", "no fault on clean request", f, 0);
  endtask

  task automatic t_cfg_reject;
    int b; bit f; int bb, bc, bu, bh;
    write_cfg(13'd48);
    check(cfg_err, "R2", "48 rejected", cfg_err, 1);
    write_cfg(13'd4);
    check(cfg_err, "R2", "4 below bus width rejected", cfg_err, 1);
    write_cfg(13'd0);
    check(cfg_err, "R2", "0 rejected", cfg_err, 1);
    run_op(32'h0000_0100, 1'b0, 1'b1, 1'b0, -1, 1'b0, 64, b, f, bb, bc, bu, bh);
    check(bc == 0 && b == 8, "R2", "size stays 64 after rejects", b, 8);
  endtask

  task automatic t_io_bytes;
    int b; bit f; int bb, bc, bu, bh;
    write_cfg(13'd16);
    check(!cfg_err, "R2", "16 accepted", cfg_err, 0);
    run_op(32'h2000_003B, 1'b1, 1'b1, 1'b0, -1, 1'b0, 16, b, f, bb, bc, bu, bh);
    check(b == 16, "R6", "byte beats for 16B io", b, 16);
    check(bb == 0, "R6", "byte beat address/strobe errors", bb, 0);
    check(bc == 0, "R3", "io aligned base 0x20000030", bc, 0);
  endtask

  task automatic t_deny;
    int b; bit f; int bb, bc, bu, bh;
    run_op(32'h0000_4444, 1'b0, 1'b0, 1'b0, -1, 1'b0, 16, b, f, bb, bc, bu, bh);
    check(b == 0, "R4", "no writes after denial", b, 0);
    check(f, "R4", "denial reports fault", f, 1);
  endtask

  task automatic t_stall;
    int b; bit f; int bb, bc, bu, bh;
    run_op(32'h0000_8009, 1'b1, 1'b1, 1'b1, -1, 1'b0, 16, b, f, bb, bc, bu, bh);
    check(bh == 0, "R7", "beat held while stalled", bh, 0);
    check(b == 16 && bb == 0, "R7", "stalled byte run complete", b, 16);
  endtask

  task automatic t_fault;
    int b; bit f; int bb, bc, bu, bh;
    write_cfg(13'd64);
    run_op(32'h0001_0000, 1'b0, 1'b1, 1'b0, 2, 1'b0, 64, b, f, bb, bc, bu, bh);
    check(b == 3, "R8", "no beats after faulting beat", b, 3);
    check(f, "R8", "beat fault reported", f, 1);
  endtask

  task automatic t_busy;
    int b; bit f; int bb, bc, bu, bh;
    int extra;
    run_op(32'h0002_0010, 1'b0, 1'b1, 1'b0, -1, 1'b1, 64, b, f, bb, bc, bu, bh);
    check(bu == 0, "R9", "req_ready low while busy", bu, 0);
    check(bc == 0, "R9", "held request did not alter block", bc, 0);
    extra = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (chk_valid || mem_valid) extra++;
    end
    check(extra == 0, "R9", "held request not taken", extra, 0);
  endtask

  initial begin
    n_total = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_size = '0; req_valid = 1'b0;
    req_addr = '0; req_io = 1'b0; chk_resp_valid = 1'b0; chk_ok = 1'b0;
    mem_ready = 1'b0; mem_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_default();
    t_cfg_reject();
    t_io_bytes();
    t_deny();
    t_stall();
    t_fault();
    t_busy();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule